// File: doc/BRIEF.md
# FP64 Range Select Unit

This block picks one of two double-precision operands by one of four orderings: signed minimum, signed maximum, smaller magnitude or larger magnitude. It then rewrites the sign bit of the picked value under a separate control. Both choices come from the low nibble of an 8-bit control byte. NaN operands, signed zeros of opposite sign and operands of equal magnitude but opposite sign are resolved by fixed rules. As a result, control byte 0x02 with a bound in the second operand clamps the first operand into a symmetric interval and keeps its sign.

The operand sits in the low 64 bits of a 128-bit lane. The upper 64 bits of the lane are passed from the first source. A one-bit write mask decides whether the new low half is written. When it is not written, the old destination value is kept (merge) or zero is written (zeroing). Invalid, denormal and illegal-control status flags come out alongside the result. A denormals-are-zero input flushes subnormal operands before they are compared. One request may enter per clock, and every output is registered one cycle after the request.

Top module: `fp_range_unit`

## Requirements
- R1: `ctrl[1:0]` selects the ordering. 00 gives the signed minimum, 01 the signed maximum, 10 the operand with the smaller magnitude and 11 the operand with the larger magnitude. Magnitude means bits [62:0]. On a tie under the less-or-equal test, 00 and 10 return the first operand and 01 and 11 return the second.
- R2: `ctrl[3:2]` selects the result sign. 00 takes the first operand's sign, 01 keeps the picked operand's sign, 10 forces 0 and 11 forces 1. Bits [62:0] of the result always come from the picked operand.
- R3: `flag_bad_ctrl` is 1 in the cycle after a valid request whose `ctrl[7:4]` is non-zero, and 0 otherwise. The low nibble still acts normally.
- R4: A NaN has exponent all ones and a non-zero fraction. It is quiet when fraction bit 51 is 1. If the second operand is a quiet NaN, the first operand is returned. Otherwise, if the first operand is a quiet NaN, the second is returned.
- R5: A signaling NaN is a NaN with fraction bit 51 equal to 0. If R4 does not apply, a signaling first operand is returned unchanged, or failing that a signaling second operand. A signaling NaN in either operand raises `flag_invalid` and bypasses the sign stage.
- R6: A denormal has exponent 0 and a non-zero fraction. With `daz` set it is replaced by a zero of the same sign before selection. With `daz` clear, `flag_denorm` is raised unless the other operand is a quiet NaN.
- R7: The low half is written when `mask_en` is 0 or `mask_bit` is 1. Otherwise the low half is `old_dst` when `zero_mode` is 0 and 0 when it is 1. A request that is not written raises neither `flag_invalid` nor `flag_denorm`.
- R8: `result[127:64]` equals `src_a[127:64]` of the request, whatever the mask.
- R9: For two zeros of opposite sign, orderings 00 and 10 pick -0.0 and orderings 01 and 11 pick +0.0.
- R10: For non-zero operands of equal magnitude and opposite sign, ordering 10 picks the negative operand and ordering 11 the positive one.
- R11: Outputs appear on the clock edge after the request, and `out_valid` follows `in_valid` by one cycle. After reset every output is 0.
- R12: With control 0x02 and a second operand of +1023.0, a first operand of magnitude at most 1023 passes through. Any other first operand becomes 1023.0 carrying the first operand's sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| src_a | input | 128 | First source lane; low 64 bits are the first operand |
| src_b | input | 64 | Second operand |
| ctrl | input | 8 | Ordering [1:0], sign mode [3:2], reserved [7:4] |
| daz | input | 1 | Flush denormal operands to zero |
| mask_en | input | 1 | Write masking enabled |
| mask_bit | input | 1 | Write mask bit for the element |
| zero_mode | input | 1 | 1: unwritten element becomes 0; 0: keeps old_dst |
| old_dst | input | 64 | Previous low half of the destination |
| out_valid | output | 1 | Result present |
| result | output | 128 | Destination lane |
| flag_invalid | output | 1 | Signaling NaN seen |
| flag_denorm | output | 1 | Denormal operand seen |
| flag_bad_ctrl | output | 1 | Reserved control bits non-zero |

## Verification
The sign override and the signaling-NaN bypass can act on the same request. Since both may also fall on a masked-off write, they can meet the mask in the same cycle. The bench forces this with directed cases that pair a signaling NaN with a forced sign mode, first written and then masked off under merge and under zeroing. In the written case the NaN's own sign must survive and the invalid flag must rise. In the masked cases the old or zero low half must appear with both status flags low. The random stream draws NaNs, denormals, equal and sign-flipped operands and random masks independently, so these overlaps also recur among its many other combinations.

// File: rtl/fpr_pkg.sv
`timescale 1ns/1ps
package fpr_pkg;
  typedef struct packed {
    logic zero;
    logic denorm;
    logic qnan;
    logic snan;
  } fpr_class_t;

  typedef enum logic [1:0] {
    CMP_MIN     = 2'b00,
    CMP_MAX     = 2'b01,
    CMP_MIN_MAG = 2'b10,
    CMP_MAX_MAG = 2'b11
  } fpr_cmp_e;

  typedef enum logic [1:0] {
    SGN_FIRST = 2'b00,
    SGN_KEEP  = 2'b01,
    SGN_CLEAR = 2'b10,
    SGN_SET   = 2'b11
  } fpr_sgn_e;
endpackage

// File: rtl/fpr_classify.sv
`timescale 1ns/1ps
module fpr_classify
  import fpr_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] raw,
  input  logic                  daz,
  output logic [EXP_W+FRAC_W:0] eff,
  output fpr_class_t            cls
);
  localparam int W = 1 + EXP_W + FRAC_W;

  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;
  logic              exp_max, exp_min, frac_nz;

  assign expo    = raw[W-2:FRAC_W];
  assign frac    = raw[FRAC_W-1:0];
  assign exp_max = &expo;
  assign exp_min = ~|expo;
  assign frac_nz = |frac;

  always_comb begin
    cls.denorm = exp_min & frac_nz;
    cls.qnan   = exp_max & frac[FRAC_W-1];
    cls.snan   = exp_max & frac_nz & ~frac[FRAC_W-1];
    cls.zero   = exp_min & (~frac_nz | daz);
    if (daz && cls.denorm) eff = {raw[W-1], {(W-1){1'b0}}};
    else                   eff = raw;
  end
endmodule

// File: rtl/fpr_select.sv
`timescale 1ns/1ps
module fpr_select
  import fpr_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] op_a,
  input  logic [EXP_W+FRAC_W:0] op_b,
  input  fpr_class_t            cls_a,
  input  fpr_class_t            cls_b,
  input  fpr_cmp_e              cmp,
  output logic [EXP_W+FRAC_W:0] picked,
  output logic                  invalid
);
  localparam int W = 1 + EXP_W + FRAC_W;

  logic [W-1:0] key_a, key_b, ordered;
  logic         signed_le, mag_le, le, opp_sign, same_mag;

  always_comb begin
    key_a     = op_a[W-1] ? ~op_a : {1'b1, op_a[W-2:0]};
    key_b     = op_b[W-1] ? ~op_b : {1'b1, op_b[W-2:0]};
    signed_le = key_a <= key_b;
    mag_le    = op_a[W-2:0] <= op_b[W-2:0];
    le        = cmp[1] ? mag_le : signed_le;
    ordered   = cmp[0] ? (le ? op_b : op_a) : (le ? op_a : op_b);
    opp_sign  = op_a[W-1] ^ op_b[W-1];
    same_mag  = op_a[W-2:0] == op_b[W-2:0];
    invalid   = cls_a.snan | cls_b.snan;

    if (cls_b.qnan)                            picked = op_a;
    else if (cls_a.qnan)                       picked = op_b;
    else if (cls_a.snan)                       picked = op_a;
    else if (cls_b.snan)                       picked = op_b;
    else if (cls_a.zero && cls_b.zero && opp_sign)
      picked = {~cmp[0], {(W-1){1'b0}}};
    else if (cmp[1] && same_mag && opp_sign)
      picked = (cmp[0] ^ op_a[W-1]) ? op_a : op_b;
    else                                       picked = ordered;
  end
endmodule

// File: rtl/fpr_finish.sv
`timescale 1ns/1ps
module fpr_finish
  import fpr_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] picked,
  input  logic         first_sign,
  input  fpr_sgn_e     sgn,
  input  logic         invalid,
  input  logic         wr_en,
  input  logic         zero_mode,
  input  logic [W-1:0] old_lo,
  output logic [W-1:0] new_lo
);
  logic sign_bit;

  always_comb begin
    unique case (sgn)
      SGN_FIRST: sign_bit = first_sign;
      SGN_KEEP:  sign_bit = picked[W-1];
      SGN_CLEAR: sign_bit = 1'b0;
      default:   sign_bit = 1'b1;
    endcase
    if (invalid) sign_bit = picked[W-1];

    if (wr_en)          new_lo = {sign_bit, picked[W-2:0]};
    else if (zero_mode) new_lo = '0;
    else                new_lo = old_lo;
  end
endmodule

// File: rtl/fp_range_unit.sv
`timescale 1ns/1ps
module fp_range_unit
  import fpr_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int LANE_W = 128,
  parameter int CTRL_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic [LANE_W-1:0]            src_a,
  input  logic [EXP_W+FRAC_W:0]        src_b,
  input  logic [CTRL_W-1:0]            ctrl,
  input  logic                         daz,
  input  logic                         mask_en,
  input  logic                         mask_bit,
  input  logic                         zero_mode,
  input  logic [EXP_W+FRAC_W:0]        old_dst,
  output logic                         out_valid,
  output logic [LANE_W-1:0]            result,
  output logic                         flag_invalid,
  output logic                         flag_denorm,
  output logic                         flag_bad_ctrl
);
  localparam int W    = 1 + EXP_W + FRAC_W;
  localparam int HI_W = LANE_W - W;

  logic [W-1:0] raw_op [2];
  logic [W-1:0] eff_op [2];
  fpr_class_t   cls_op [2];

  assign raw_op[0] = src_a[W-1:0];
  assign raw_op[1] = src_b;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fpr_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .raw (raw_op[g]),
      .daz (daz),
      .eff (eff_op[g]),
      .cls (cls_op[g])
    );
  end

  logic [W-1:0] picked, new_lo;
  logic         invalid, denorm_hit, wr_en, bad_ctrl;

  fpr_select #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_sel (
    .op_a    (eff_op[0]),
    .op_b    (eff_op[1]),
    .cls_a   (cls_op[0]),
    .cls_b   (cls_op[1]),
    .cmp     (fpr_cmp_e'(ctrl[1:0])),
    .picked  (picked),
    .invalid (invalid)
  );

  assign wr_en = ~mask_en | mask_bit;

  fpr_finish #(.W(W)) u_fin (
    .picked     (picked),
    .first_sign (src_a[W-1]),
    .sgn        (fpr_sgn_e'(ctrl[3:2])),
    .invalid    (invalid),
    .wr_en      (wr_en),
    .zero_mode  (zero_mode),
    .old_lo     (old_dst),
    .new_lo     (new_lo)
  );

  assign denorm_hit = ~daz & ((cls_op[0].denorm & ~cls_op[1].qnan) |
                              (cls_op[1].denorm & ~cls_op[0].qnan));
  assign bad_ctrl   = |ctrl[CTRL_W-1:4];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      result        <= '0;
      flag_invalid  <= 1'b0;
      flag_denorm   <= 1'b0;
      flag_bad_ctrl <= 1'b0;
    end else begin
      out_valid     <= in_valid;
      result        <= {src_a[LANE_W-1:LANE_W-HI_W], new_lo};
      flag_invalid  <= in_valid & wr_en & invalid;
      flag_denorm   <= in_valid & wr_en & denorm_hit;
      flag_bad_ctrl <= in_valid & bad_ctrl;
    end
  end
endmodule

// File: rtl/fpr_checker.sv
`timescale 1ns/1ps
module fpr_checker #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int LANE_W = 128,
  parameter int CTRL_W = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic [LANE_W-1:0]     src_a,
  input logic [EXP_W+FRAC_W:0] src_b,
  input logic [CTRL_W-1:0]     ctrl,
  input logic                  daz,
  input logic                  mask_en,
  input logic                  mask_bit,
  input logic                  zero_mode,
  input logic [EXP_W+FRAC_W:0] old_dst,
  input logic                  out_valid,
  input logic [LANE_W-1:0]     result,
  input logic                  flag_invalid,
  input logic                  flag_denorm,
  input logic                  flag_bad_ctrl
);
  localparam int W = 1 + EXP_W + FRAC_W;

  logic sig_a, sig_b, written;
  assign sig_a   = (&src_a[W-2:FRAC_W]) & (|src_a[FRAC_W-1:0]) & ~src_a[FRAC_W-1];
  assign sig_b   = (&src_b[W-2:FRAC_W]) & (|src_b[FRAC_W-1:0]) & ~src_b[FRAC_W-1];
  assign written = ~mask_en | mask_bit;

  p_valid_follow_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> out_valid == $past(in_valid));

  p_upper_pass_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> result[LANE_W-1:W] == $past(src_a[LANE_W-1:W]));

  p_merge_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask_en && !mask_bit && !zero_mode) |=>
      (result[W-1:0] == $past(old_dst)) && !flag_invalid && !flag_denorm);

  p_zero_fill_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask_en && !mask_bit && zero_mode) |=>
      (result[W-1:0] == '0) && !flag_invalid && !flag_denorm);

  p_bad_ctrl_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> flag_bad_ctrl == (|$past(ctrl[CTRL_W-1:4])));

  p_force_sign_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && written && ctrl[3:2] == 2'b11 && !sig_a && !sig_b) |=> result[W-1]);

  p_invalid_raise_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && written && (sig_a || sig_b)) |=> flag_invalid);
endmodule

bind fp_range_unit fpr_checker #(
  .EXP_W(EXP_W), .FRAC_W(FRAC_W), .LANE_W(LANE_W), .CTRL_W(CTRL_W)
) u_chk (.*);

// File: tb/fp_range_unit_test.sv
`timescale 1ns/1ps
module fp_range_unit_test;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [127:0] src_a;
  logic [63:0]  src_b;
  logic [7:0]   ctrl;
  logic         daz, mask_en, mask_bit, zero_mode;
  logic [63:0]  old_dst;
  logic         out_valid;
  logic [127:0] result;
  logic         flag_invalid, flag_denorm, flag_bad_ctrl;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  fp_range_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .ctrl(ctrl), .daz(daz), .mask_en(mask_en), .mask_bit(mask_bit),
    .zero_mode(zero_mode), .old_dst(old_dst), .out_valid(out_valid),
    .result(result), .flag_invalid(flag_invalid), .flag_denorm(flag_denorm),
    .flag_bad_ctrl(flag_bad_ctrl)
  );

  function automatic bit is_q(input logic [63:0] x);
    return (x[62:52] == 11'h7ff) && x[51];
  endfunction
  function automatic bit is_s(input logic [63:0] x);
    return (x[62:52] == 11'h7ff) && !x[51] && (x[50:0] != 0);
  endfunction
  function automatic bit is_d(input logic [63:0] x);
    return (x[62:52] == 0) && (x[51:0] != 0);
  endfunction

  // Expected {bad, denorm, invalid, low64} from the requirement text
  function automatic logic [66:0] model(input logic [63:0] a0, input logic [63:0] b0,
      input logic [7:0] c, input bit dz, input bit men, input bit mb, input bit zm,
      input logic [63:0] old);
    logic [63:0] a, b, t, r;
    bit inv, den, le, bad, wr;
    a = a0; b = b0;
    den = !dz && ((is_d(a0) && !is_q(b0)) || (is_d(b0) && !is_q(a0)));
    if (dz && is_d(a0)) a = {a0[63], 63'd0};
    if (dz && is_d(b0)) b = {b0[63], 63'd0};
    inv = is_s(a0) || is_s(b0);
    if (is_q(b)) t = a;
    else if (is_q(a)) t = b;
    else if (is_s(a)) t = a;
    else if (is_s(b)) t = b;
    else if (a[62:0] == 0 && b[62:0] == 0 && a[63] != b[63]) t = {~c[0], 63'd0};
    else if (c[1] && a[62:0] == b[62:0] && a[63] != b[63])
      t = c[0] ? (a[63] ? b : a) : (a[63] ? a : b);
    else begin
      if (c[1]) le = a[62:0] <= b[62:0];
      else if (a[63] != b[63]) le = a[63];
      else if (!a[63]) le = a[62:0] <= b[62:0];
      else le = a[62:0] >= b[62:0];
      t = c[0] ? (le ? b : a) : (le ? a : b);
    end
    r = t;
    if (!inv) begin
      case (c[3:2])
        2'b00: r[63] = a0[63];
        2'b01: r[63] = t[63];
        2'b10: r[63] = 1'b0;
        default: r[63] = 1'b1;
      endcase
    end
    wr = !men || mb;
    if (!wr) begin
      r = zm ? 64'd0 : old;
      inv = 0; den = 0;
    end
    bad = c[7:4] != 0;
    return {bad, den, inv, r};
  endfunction

  task automatic compare(input string tag, input logic [127:0] er, input bit ei,
      input bit ed, input bit eb, input bit ev);
    checks++;
    if (result !== er || flag_invalid !== ei || flag_denorm !== ed ||
        flag_bad_ctrl !== eb || out_valid !== ev) begin
      errors++;
      $display("FAIL %s: got res=%h inv=%b den=%b bad=%b v=%b, expected res=%h inv=%b den=%b bad=%b v=%b",
        tag, result, flag_invalid, flag_denorm, flag_bad_ctrl, out_valid,
        er, ei, ed, eb, ev);
    end
  endtask

  // Drive one request at a falling edge; sample at the next falling edge
  task automatic run(input string tag, input logic [127:0] a, input logic [63:0] b,
      input logic [7:0] c, input bit dz, input bit men, input bit mb, input bit zm,
      input logic [63:0] old);
    logic [66:0] e;
    @(negedge clk);
    in_valid = 1; src_a = a; src_b = b; ctrl = c; daz = dz;
    mask_en = men; mask_bit = mb; zero_mode = zm; old_dst = old;
    e = model(a[63:0], b, c, dz, men, mb, zm, old);
    @(negedge clk);
    in_valid = 0;
    compare(tag, {a[127:64], e[63:0]}, e[64], e[65], e[66], 1'b1);
  endtask

  task automatic run_exp(input string tag, input logic [63:0] a, input logic [63:0] b,
      input logic [7:0] c, input logic [63:0] er, input bit ei);
    @(negedge clk);
    in_valid = 1; src_a = {64'h0123_4567_89ab_cdef, a}; src_b = b; ctrl = c;
    daz = 0; mask_en = 0; mask_bit = 0; zero_mode = 0; old_dst = '0;
    @(negedge clk);
    in_valid = 0;
    compare(tag, {64'h0123_4567_89ab_cdef, er}, ei, 1'b0, 1'b0, 1'b1);
  endtask

  function automatic logic [63:0] pick(input logic [63:0] other);
    logic [63:0] x;
    logic s;
    s = $urandom % 2;
    case ($urandom % 9)
      0: x = {$urandom, $urandom};
      1: x = {s, 63'd0};
      2: x = {s, 11'd0, 20'($urandom), $urandom | 32'd1};
      3: x = {s, 11'h7ff, 1'b1, 19'($urandom), $urandom};
      4: x = {s, 11'h7ff, 1'b0, 19'($urandom), $urandom | 32'd1};
      5: x = {s, 11'h7ff, 52'd0};
      6: x = {~other[63], other[62:0]};
      7: x = other;
      default: x = {s, 11'h3f0 + 11'($urandom % 32), 20'($urandom), $urandom};
    endcase
    return x;
  endfunction

  localparam logic [63:0] PZ = 64'h0, NZ = 64'h8000_0000_0000_0000;
  localparam logic [63:0] SN = 64'hFFF0_0000_0000_0001;

  initial begin
    logic [63:0] k1023, kn1023, sn_pos;
    k1023  = $realtobits(1023.0);
    kn1023 = $realtobits(-1023.0);
    sn_pos = 64'h7FF0_0000_0000_0005;
    void'($urandom(32'd20240611));
    rst = 1; in_valid = 0; src_a = '0; src_b = '0; ctrl = '0; daz = 0;
    mask_en = 0; mask_bit = 0; zero_mode = 0; old_dst = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    compare("R11 reset", 128'd0, 0, 0, 0, 0);
    rst = 0;

    // R1: orderings and tie rules
    run_exp("R1 min", $realtobits(-2.0), $realtobits(1.5), 8'h04, $realtobits(-2.0), 0);
    run_exp("R1 max", $realtobits(-2.0), $realtobits(1.5), 8'h04 | 8'h01, $realtobits(1.5), 0);
    run_exp("R1 minmag", $realtobits(-2.0), $realtobits(1.5), 8'h06, $realtobits(1.5), 0);
    run_exp("R1 maxmag", $realtobits(-2.0), $realtobits(1.5), 8'h07, $realtobits(-2.0), 0);
    run_exp("R1 tie max", 64'h4000_0000_0000_0001, 64'h4000_0000_0000_0001, 8'h05,
            64'h4000_0000_0000_0001, 0);
    // R2: sign modes
    run_exp("R2 first sign", $realtobits(-3.0), $realtobits(7.0), 8'h01, $realtobits(-7.0), 0);
    run_exp("R2 clear", $realtobits(-3.0), $realtobits(-7.0), 8'h08, $realtobits(7.0), 0);
    run_exp("R2 set", $realtobits(3.0), $realtobits(7.0), 8'h0D, $realtobits(-7.0), 0);
    // R4: quiet NaN rules
    run_exp("R4 b qnan", $realtobits(2.0), 64'hFFF8_0000_0000_0000, 8'h04,
            $realtobits(2.0), 0);
    run_exp("R4 a qnan", 64'h7FF8_0000_0000_0001, $realtobits(-9.0), 8'h04,
            $realtobits(-9.0), 0);
    // R5: signaling NaN with forced sign, written, then masked merge and zero
    run_exp("R5 snan bypass", sn_pos, $realtobits(1.0), 8'h0C, sn_pos, 1);
    run("R5 R7 snan merge", {64'hAAAA, sn_pos}, PZ, 8'h0C, 0, 1, 0, 0, 64'h1234);
    run("R5 R7 snan zero", {64'hBBBB, SN}, PZ, 8'h0C, 0, 1, 0, 1, 64'h1234);
    // R6: denormals
    run("R6 denorm flag", {64'h0, 64'h0000_0000_0000_0003}, $realtobits(1.0), 8'h04,
        0, 0, 0, 0, 0);
    run("R6 denorm vs qnan", {64'h0, 64'h0000_0000_0000_0003}, 64'h7FF8_0000_0000_0000,
        8'h04, 0, 0, 0, 0, 0);
    run_exp("R6 daz base", $realtobits(1.0), $realtobits(1.0), 8'h04, $realtobits(1.0), 0);
    @(negedge clk);
    in_valid = 1; src_a = {64'h0, 64'h8000_0000_0000_0007}; src_b = PZ; ctrl = 8'h05;
    daz = 1; mask_en = 0;
    @(negedge clk);
    in_valid = 0;
    compare("R6 daz flush to -0 vs +0 max", 128'd0, 0, 0, 0, 1);
    daz = 0;
    // R9: opposite zeros
    run_exp("R9 min zeros", PZ, NZ, 8'h04, NZ, 0);
    run_exp("R9 maxmag zeros", NZ, PZ, 8'h07, PZ, 0);
    // R10: equal magnitude opposite sign
    run_exp("R10 minmag", $realtobits(5.0), $realtobits(-5.0), 8'h06, $realtobits(-5.0), 0);
    run_exp("R10 maxmag", $realtobits(-5.0), $realtobits(5.0), 8'h07, $realtobits(5.0), 0);
    // R3: reserved bits
    run("R3 bad ctrl", {64'h5, $realtobits(1.0)}, $realtobits(2.0), 8'h91, 0, 0, 0, 0, 0);
    // R8: upper half under zero mask
    run("R8 upper pass", {64'hDEAD_BEEF_0000_0001, $realtobits(1.0)}, $realtobits(2.0),
        8'h00, 0, 1, 0, 1, 64'h9);
    // R12: clamp
    run_exp("R12 clamp high", $realtobits(2000.0), k1023, 8'h02, k1023, 0);
    run_exp("R12 clamp low", $realtobits(-5000.0), k1023, 8'h02, kn1023, 0);
    run_exp("R12 inside", $realtobits(-3.5), k1023, 8'h02, $realtobits(-3.5), 0);
    run_exp("R12 edge", kn1023, k1023, 8'h02, kn1023, 0);
    // R11: idle cycle drops out_valid
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R11 idle: got out_valid=%b, expected 0", out_valid);
    end

    // Random mix: R1 R2 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] ra, rb;
      logic [7:0] rc;
      ra = pick({$urandom, $urandom});
      rb = pick(ra);
      rc = ($urandom % 8 == 0) ? 8'($urandom) : {4'd0, 4'($urandom)};
      run("R1 random", {$urandom, $urandom, ra}, rb, rc, $urandom % 2, $urandom % 2,
          $urandom % 2, $urandom % 2, {$urandom, $urandom});
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule